// File: doc/BRIEF.md
# Power-Aware Decimated Carrier Frequency Offset Estimator

This block measures the carrier frequency offset of an incoming OFDM packet from a repeated preamble. It correlates received samples against copies taken three symbol lengths earlier. To save storage and multiplies, it keeps only one sample in every λ of the first symbol of each window. The phase of the summed complex product is found by an iterative vectoring rotator. That phase is then scaled by the reciprocal of the lag, which gives a phase increment per sample that a downstream compensator can apply.

Each packet is processed in two windows of four symbols each. The first window always runs a cheap coarse pass with a sparse decimation factor. The coarse figure is only used to make a decision. If it lies further than a programmable threshold from the last published fine figure, the second window runs the dense fine pass and its result is published. Otherwise the block publishes the previous fine figure again and ignores the rest of the packet. Both passes share one complex multiplier, one accumulator and one angle unit, because they never overlap in time.

Top module: `cfo_pa_est`

## Requirements
- R1: While reset is held and after its release, `est` is 0 and `est_valid` is 0 until a packet has been processed.
- R2: For a packet whose fine window (valid samples 4N..8N-1 after `start`, N = 165) carries a pure tone of phase step w rad/sample, the published `est` equals w·2^(AW+ceil(log2(3N)))/(2π) within ±48 LSB (LSB = 2π/2^25 rad at defaults). This holds for tones whose phase over 3N samples stays inside ±π, for any amplitude up to full scale. Only samples at window indices k·λ (k < floor(N/λ)) and their partners 3N later enter the sum, with λ = 4 for fine and λ = 64 for coarse.
- R3: The first packet after reset always runs the fine pass, whatever the threshold.
- R4: If |coarse − last fine| ≤ `thresh` (same units as `est`), `est_valid` pulses with `est` unchanged, and the fine-window samples have no effect.
- R5: If |coarse − last fine| > `thresh`, the fine pass runs and its result is published on `est`.
- R6: The coarse figure is never driven onto `est`.
- R7: Each packet that completes yields exactly one single-cycle `est_valid` pulse. `est` changes only in a cycle where `est_valid` is high, and no pulse occurs before the first `start`.
- R8: Cycles with `in_valid` low are skipped and do not change the result.
- R9: A `start` during collection abandons that packet without any pulse. The sample in the `start` cycle is ignored, and the next valid sample is index 0.
- R10: A fine result already in the angle stage is still published when a new `start` arrives in any cycle before or at its completion, and the new packet proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Packet start pulse |
| in_valid | input | 1 | Sample qualifier |
| in_i | input | W | In-phase sample, signed |
| in_q | input | W | Quadrature sample, signed |
| thresh | input | AW+1 | Unsigned decision threshold in `est` units |
| est | output | AW+1 | Signed per-sample phase increment |
| est_valid | output | 1 | One-cycle pulse when `est` is published or confirmed |

## Verification
The fine pass publishing its result and a new packet `start` can fall in the same cycle. The angle unit of the old packet is still busy while the collector of the new one is being cleared. The bench provokes this by sweeping the gap between the last sample of one packet and the next `start` across the rotator latency, so one sweep step lands exactly on the publishing edge. It judges each step by requiring exactly two pulses carrying the first packet's tone and then the second's. The table of packets pairs different coarse and fine tones, so the value on `est` shows which pass was taken.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CCOL,
      ST_CANG,
      ST_GAP,
      ST_FCOL,
      ST_FANG
   } cfo_state_e;
endpackage

// File: rtl/cfo_dec_corr.sv
module cfo_dec_corr #(
   parameter int W    = 12,
   parameter int N    = 165,
   parameter int LAG  = 495,
   parameter int LF   = 4,
   parameter int LC   = 64,
   parameter int IW   = 11,
   parameter int ACCW = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   en,
   input  logic                   fine,
   input  logic [IW-1:0]          idx,
   input  logic signed [W-1:0]    in_i,
   input  logic signed [W-1:0]    in_q,
   output logic signed [ACCW-1:0] acc_i,
   output logic signed [ACCW-1:0] acc_q
);
   localparam int NF = N / LF;
   localparam int NC = N / LC;
   localparam int SF = $clog2(LF);
   localparam int SC = $clog2(LC);
   localparam int SW = $clog2(NF);
   localparam int PW = 2 * W + 1;

   logic signed [W-1:0] mem_i [NF];
   logic signed [W-1:0] mem_q [NF];

   logic [IW-1:0] rel, mask, nprod, slot_st, slot_rd;
   logic          st_hit, cr_hit;
   logic signed [W-1:0]  a_i, a_q;
   logic signed [PW-1:0] p_re, p_im;

   always_comb begin
      mask    = fine ? IW'(LF - 1) : IW'(LC - 1);
      nprod   = fine ? IW'(NF) : IW'(NC);
      rel     = idx - IW'(LAG);
      slot_st = fine ? (idx >> SF) : (idx >> SC);
      slot_rd = fine ? (rel >> SF) : (rel >> SC);
      st_hit  = en && (idx < IW'(N)) && ((idx & mask) == '0) && (slot_st < nprod);
      cr_hit  = en && (idx >= IW'(LAG)) && ((rel & mask) == '0) && (slot_rd < nprod);
      a_i     = mem_i[slot_rd[SW-1:0]];
      a_q     = mem_q[slot_rd[SW-1:0]];
      // conj(stored) * new : angle grows with the offset
      p_re    = PW'(a_i) * PW'(in_i) + PW'(a_q) * PW'(in_q);
      p_im    = PW'(a_i) * PW'(in_q) - PW'(a_q) * PW'(in_i);
   end

   always_ff @(posedge clk) begin
      if (st_hit) begin
         mem_i[slot_st[SW-1:0]] <= in_i;
         mem_q[slot_st[SW-1:0]] <= in_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc_i <= '0;
         acc_q <= '0;
      end else if (cr_hit) begin
         acc_i <= acc_i + ACCW'(p_re);
         acc_q <= acc_q + ACCW'(p_im);
      end
   end
endmodule

// File: rtl/cfo_cordic_vec.sv
module cfo_cordic_vec #(
   parameter int XW   = 32,
   parameter int AW   = 16,
   parameter int ITER = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic signed [XW-1:0] x_in,
   input  logic signed [XW-1:0] y_in,
   output logic                 done,
   output logic signed [AW-1:0] ang
);
   localparam int  XI = XW + 2;
   localparam int  CW = $clog2(ITER);
   localparam real PI = 3.14159265358979;

   logic [AW-1:0] at_tab [ITER];

   for (genvar g = 0; g < ITER; g++) begin : g_atan
      localparam real AR = $atan(2.0 ** (-g)) * (2.0 ** AW) / (2.0 * PI);
      assign at_tab[g] = AW'($rtoi(AR + 0.5));
   end

   logic signed [XI-1:0] x, y, dx, dy;
   logic [AW-1:0]        z;
   logic [CW-1:0]        it;
   logic                 busy;

   always_comb begin
      dx = x >>> it;
      dy = y >>> it;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x <= '0; y <= '0; z <= '0; it <= '0;
         busy <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            busy <= 1'b1;
            it   <= '0;
            if (x_in < 0) begin
               x <= -XI'(x_in);
               y <= -XI'(y_in);
               z <= AW'(1) << (AW - 1);
            end else begin
               x <= XI'(x_in);
               y <= XI'(y_in);
               z <= '0;
            end
         end else if (busy) begin
            if (y >= 0) begin
               x <= x + dy;
               y <= y - dx;
               z <= z + at_tab[it];
            end else begin
               x <= x - dy;
               y <= y + dx;
               z <= z - at_tab[it];
            end
            it <= it + 1'b1;
            if (it == CW'(ITER - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign ang = $signed(z);
endmodule

// File: rtl/cfo_pa_est.sv
module cfo_pa_est #(
   parameter int W    = 12,
   parameter int N    = 165,
   parameter int LF   = 4,
   parameter int LC   = 64,
   parameter int AW   = 16,
   parameter int ITER = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 in_valid,
   input  logic signed [W-1:0]  in_i,
   input  logic signed [W-1:0]  in_q,
   input  logic [AW:0]          thresh,
   output logic signed [AW:0]   est,
   output logic                 est_valid
);
   import cfo_pkg::*;

   localparam int LAG    = 3 * N;
   localparam int WIN    = 4 * N;
   localparam int NF     = N / LF;
   localparam int NC     = N / LC;
   localparam int ACCW   = 2 * W + 2 + $clog2(NF);
   localparam int CNTW   = $clog2(2 * WIN + 1);
   localparam int LAST_C = LAG + (NC - 1) * LC;
   localparam int LAST_F = LAG + (NF - 1) * LF;
   localparam int FRAC   = $clog2(LAG);
   localparam int RSH    = AW;
   localparam int RECIP  = ((2 ** (RSH + FRAC)) + LAG / 2) / LAG;
   localparam int RW     = $clog2(RECIP) + 2;
   localparam int MW     = AW + RW;

   if ((LF & (LF - 1)) != 0 || (LC & (LC - 1)) != 0) begin : g_bad_pow2
      $error("decimation factors must be powers of two");
   end
   if (LC <= LF || N < 2 * LC || NF < 2) begin : g_bad_ratio
      $error("coarse factor must exceed fine factor and leave two products");
   end
   if (LAST_C + ITER + 4 >= WIN) begin : g_bad_gap
      $error("angle stage cannot finish before the fine window");
   end
   if (ITER < 2 || ITER > AW || AW + FRAC > 30) begin : g_bad_angle
      $error("angle width or iteration count out of range");
   end

   cfo_state_e state;
   logic [CNTW-1:0]        cnt, idx;
   logic                   kick, ang_fine, have_fine;
   logic signed [AW:0]     last_fine, scaled;
   logic signed [ACCW-1:0] acc_i, acc_q;
   logic signed [AW-1:0]   ang;
   logic                   ang_done;
   logic                   fine_sel, col_en, fire, clr, coarse_done, need_fine;
   logic signed [MW-1:0]   mulv, rnd;
   logic signed [AW+1:0]   diff;
   logic [AW+1:0]          adiff;

   always_comb begin
      fine_sel    = (state == ST_FCOL);
      idx         = fine_sel ? cnt - CNTW'(WIN) : cnt;
      col_en      = in_valid && !start && (state == ST_CCOL || fine_sel);
      fire        = col_en && (fine_sel ? (cnt == CNTW'(WIN + LAST_F))
                                        : (cnt == CNTW'(LAST_C)));
      clr         = start || (state == ST_GAP && in_valid && cnt == CNTW'(WIN - 1));
      coarse_done = ang_done && !ang_fine && (state == ST_CANG) && !start;
      mulv        = MW'(ang) * MW'($signed(RW'(RECIP)));
      rnd         = (mulv + MW'(2 ** (RSH - 1))) >>> RSH;
      scaled      = rnd[AW:0];
      diff        = (AW+2)'(scaled) - (AW+2)'(last_fine);
      adiff       = (diff < 0) ? (AW+2)'(-diff) : (AW+2)'(diff);
      need_fine   = !have_fine || (adiff > (AW+2)'(thresh));
   end

   cfo_dec_corr #(
      .W(W), .N(N), .LAG(LAG), .LF(LF), .LC(LC), .IW(CNTW), .ACCW(ACCW)
   ) u_corr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(col_en), .fine(fine_sel),
      .idx(idx), .in_i(in_i), .in_q(in_q), .acc_i(acc_i), .acc_q(acc_q)
   );

   cfo_cordic_vec #(
      .XW(ACCW), .AW(AW), .ITER(ITER)
   ) u_cordic (
      .clk(clk), .rst_n(rst_n), .go(kick), .x_in(acc_i), .y_in(acc_q),
      .done(ang_done), .ang(ang)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         kick      <= 1'b0;
         ang_fine  <= 1'b0;
         have_fine <= 1'b0;
         last_fine <= '0;
         est       <= '0;
         est_valid <= 1'b0;
      end else begin
         est_valid <= 1'b0;
         kick      <= fire;
         if (fire) ang_fine <= fine_sel;
         if (start) cnt <= '0;
         else if (in_valid && state != ST_IDLE) cnt <= cnt + 1'b1;
         if (start) state <= ST_CCOL;
         else begin
            case (state)
               ST_CCOL: if (fire) state <= ST_CANG;
               ST_CANG: if (coarse_done) state <= need_fine ? ST_GAP : ST_IDLE;
               ST_GAP:  if (clr) state <= ST_FCOL;
               ST_FCOL: if (fire) state <= ST_FANG;
               ST_FANG: if (ang_done) state <= ST_IDLE;
               default: state <= ST_IDLE;
            endcase
         end
         if (ang_done && ang_fine) begin
            est       <= scaled;
            last_fine <= scaled;
            have_fine <= 1'b1;
            est_valid <= 1'b1;
         end else if (coarse_done && !need_fine) begin
            est_valid <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfo_pa_est_chk.sv
module cfo_pa_est_chk #(
   parameter int AW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              est_valid,
   input logic signed [AW:0] est,
   input logic              have_fine
);
   logic seen_start;

   always_ff @(posedge clk) begin
      if (!rst_n) seen_start <= 1'b0;
      else if (start) seen_start <= 1'b1;
   end

   p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      est_valid |=> !est_valid);

   p_est_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(est) |-> est_valid);

   p_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      est_valid |-> seen_start);

   // R3: a skip verdict can only exist once a fine figure has been stored
   p_fine_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
      est_valid |-> have_fine);
endmodule

bind cfo_pa_est cfo_pa_est_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .est_valid(est_valid),
   .est(est), .have_fine(have_fine)
);

// File: tb/cfo_pa_est_bench.sv
module cfo_pa_est_bench;
   localparam int  NS   = 165;
   localparam int  WIN  = 4 * NS;
   localparam int  UNIT = 2 ** 25;
   localparam int  TMAX = 131071;
   localparam int  TOL  = 48;
   localparam real PI   = 3.14159265358979;

   typedef struct packed {
      int ec; int ef; int th; int gap; int amp; int exp_v;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{9000,   3000,   TMAX, 0, 1500, 3000},
      '{3050,   8000,   200,  0, 900,  3000},
      '{6000,   -8000,  200,  2, 1500, -8000},
      '{-7990,  20000,  100,  0, 1900, -8000},
      '{20000,  20000,  0,    5, 1200, 20000},
      '{-25000, -25000, 1000, 0, 1500, -25000},
      '{-24000, 500,    2000, 3, 700,  -25000},
      '{-23000, 500,    1500, 0, 1500, 500}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic in_valid = 1'b0;
   logic signed [11:0] in_i = '0;
   logic signed [11:0] in_q = '0;
   logic [16:0] thresh = '0;
   logic signed [16:0] est;
   logic est_valid;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int hist [4];

   always #4 clk = ~clk;

   cfo_pa_est u_cfo_pa_est (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_i(in_i), .in_q(in_q), .thresh(thresh), .est(est), .est_valid(est_valid)
   );

   always @(negedge clk) begin
      if (est_valid) begin
         if (pulses < 4) hist[pulses] = int'(est);
         pulses = pulses + 1;
      end
   end

   function automatic int rnd(real x);
      return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
   endfunction

   task automatic check_near(string tag, int got, int exp_v);
      int d;
      checks++;
      d = got - exp_v;
      if (d < 0) d = -d;
      if (d > TOL) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp_v);
      end
   endtask

   task automatic check_eq(string tag, int got, int exp_v);
      checks++;
      if (got != exp_v) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp_v);
      end
   endtask

   task automatic run_packet(int ec, int ef, int amp, int gap, int th, int lead, int nsamp);
      real w, ph;
      thresh = 17'(th);
      repeat (lead) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < nsamp; n++) begin
         w  = ((n < WIN) ? real'(ec) : real'(ef)) * 2.0 * PI / real'(UNIT);
         ph = w * real'((n < WIN) ? n : n - WIN);
         in_i     = 12'(rnd(real'(amp) * $cos(ph)));
         in_q     = 12'(rnd(real'(amp) * $sin(ph)));
         in_valid = 1'b1;
         @(negedge clk);
         if (gap > 0 && (n % gap) == gap - 1) begin
            in_valid = 1'b0;
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check_eq("R1 est in reset", int'(est), 0);
      check_eq("R1 valid in reset", int'(est_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_eq("R1 est after reset", int'(est), 0);
      check_eq("R7 no pulse before start", pulses, 0);

      // table: R2 R3 R4 R5 R8 via coarse/fine tone pairs
      for (int v = 0; v < 8; v++) begin
         pulses = 0;
         run_packet(VEC[v].ec, VEC[v].ef, VEC[v].amp, VEC[v].gap, VEC[v].th, 2, 2 * WIN);
         repeat (40) @(negedge clk);
         check_eq($sformatf("R7 pulse count vec %0d", v), pulses, 1);
         check_near($sformatf("R2/R3/R4/R5/R8 est vec %0d", v), int'(est), VEC[v].exp_v);
         if (VEC[v].ec - VEC[v].exp_v > 2000 || VEC[v].exp_v - VEC[v].ec > 2000) begin
            checks++;
            if ((int'(est) - VEC[v].ec < 1000) && (VEC[v].ec - int'(est) < 1000)) begin
               errors++;
               $display("FAIL R6 coarse on output vec %0d: actual %0d expected far from %0d",
                        v, int'(est), VEC[v].ec);
            end
         end
      end

      // R9: abandon a packet mid-collection
      pulses = 0;
      run_packet(15000, 15000, 1500, 0, 0, 2, 300);
      run_packet(-12000, -12000, 1500, 0, 0, 0, 2 * WIN);
      repeat (40) @(negedge clk);
      check_eq("R9 one pulse after abort", pulses, 1);
      check_near("R9 est after abort", int'(est), -12000);

      // R10: sweep the next start across the fine angle completion
      for (int d = 13; d <= 21; d++) begin
         pulses = 0;
         run_packet(6000 + 100 * d, 6000 + 100 * d, 1500, 0, 0, 2, 2 * WIN);
         run_packet(-3000, -3000, 1500, 0, 0, d, 2 * WIN);
         repeat (40) @(negedge clk);
         check_eq($sformatf("R10 pulses lead %0d", d), pulses, 2);
         check_near($sformatf("R10 first result lead %0d", d), hist[0], 6000 + 100 * d);
         check_near($sformatf("R10 second result lead %0d", d), hist[1], -3000);
      end

      // R3 after a fresh reset, then R4 skip with a different fine tone
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R1 est cleared by reset", int'(est), 0);
      rst_n = 1'b1;
      @(negedge clk);
      pulses = 0;
      run_packet(-500, 12000, 1500, 0, TMAX, 2, 2 * WIN);
      repeat (40) @(negedge clk);
      check_near("R3 first packet runs fine", int'(est), 12000);
      pulses = 0;
      run_packet(12010, -9000, 1500, 0, 300, 2, 2 * WIN);
      repeat (40) @(negedge clk);
      check_eq("R4 skip pulse count", pulses, 1);
      check_near("R4 skip keeps previous fine", int'(est), 12000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule